// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt requests from external pins and from internal logic into a pending register of one bit per priority level. It presents the most urgent pending request that is allowed through to the processor core as a valid flag plus a level index. Level 0 is the most urgent. Higher indices are less urgent. The core services the request and pulses an acknowledge, which clears the pending bit of the level being presented.

There are nine external request pins. One is a power-down request on level 0. Six are user requests on levels 2 to 7, where user pin k maps to level 2+k. Two are I/O-level expansion requests on levels 10 and 11, where expansion pin k maps to level 10+k. Every pin goes through a two-flop synchronizer. A single sense-mode input chooses rising-edge or high-level capture for the power-down pin and the user pins. The expansion pins are always captured on the high level. Internal logic can set any level directly through a set vector.

A per-level mask register lets each level through or holds it back. A master enable also gates requests. Neither of them ever holds back the power-down level.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the pending register, the mask register and the master enable are all zero, and irq_valid is low.
- R2: When bit i of int_set is high, pending bit i is set at the next clock edge.
- R3: irq_valid is high when at least one level is eligible, and irq_level gives the lowest-numbered eligible level. A level is eligible when it is pending and allowed through.
- R4: mask_we loads mask_wdata into the mask at the clock edge. Mask bit i equal to 1 lets level i (1..15) through, and 0 holds it back.
- R5: While the master enable is 0, no level 1..15 is presented. en_we loads en_wdata into the master enable.
- R6: A pending power-down request (level 0) is presented whatever the state of mask bit 0 and the master enable.
- R7: With edge_mode=1, a rising edge on the power-down pin or a user pin sets the pending bit at the third clock edge after the pin changes. A single-cycle pulse is enough. The bit stays set until it is acknowledged, and a pin that is held high does not set it again.
- R8: With edge_mode=0, the power-down pin and the user pins set their pending bit on every cycle in which the synchronized level is high. An acknowledged bit therefore returns one cycle after the acknowledge while the pin is still high.
- R9: The two expansion pins are always captured on the high level, whatever edge_mode is.
- R10: When ack is high and irq_valid is high, only the presented level's pending bit is cleared at the clock edge. The clear takes precedence over any set of that same level in the same cycle.
- R11: The pins map to levels as follows: power-down to level 0, user pin k to level 2+k, and expansion pin k to level 10+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| edge_mode | input | 1 | 1 = rising-edge capture, 0 = high-level capture (power-down and user pins) |
| pwrdn_req | input | 1 | Power-down request pin |
| usr_req | input | 6 | User request pins |
| iol_req | input | 2 | I/O-level expansion request pins, active high |
| int_set | input | 16 | Internal request set vector, one bit per level |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 16 | Mask value, 1 = let level through |
| en_we | input | 1 | Master enable write strobe |
| en_wdata | input | 1 | Master enable value |
| ack | input | 1 | Acknowledge of the presented level |
| irq_valid | output | 1 | An eligible request is presented |
| irq_level | output | 4 | Index of the presented level |
| pend_o | output | 16 | Pending register |

## Verification
The following behaviours are checked on every cycle:
- A presented level is always pending.
- A pending power-down request always wins.
- A disabled or masked level is never presented.
- An acknowledge clears the presented bit.
- An internal set always lands in the pending register.

Only the bench's scenarios show the timing and the capture modes: the three-edge latency from a pin, edge capture that holds a bit until it is acknowledged, level capture that re-arms after an acknowledge, the expansion pins ignoring the mode, and the mapping from pins to levels.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic {
      SENSE_LEVEL = 1'b0,
      SENSE_EDGE  = 1'b1
   } sense_e;

   localparam int unsigned PWRDN_LEVEL = 0;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int unsigned WIDTH  = 9,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage_q[s] <= '0;
         end else if (s == 0) begin
            stage_q[s] <= async_in;
         end else begin
            stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
   parameter int unsigned      WIDTH = 9,
   parameter logic [WIDTH-1:0] CFG   = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  irq_pkg::sense_e  sense,
   input  logic [WIDTH-1:0] lvl_in,
   output logic [WIDTH-1:0] set_out
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
      end else begin
         prev_q <= lvl_in;
      end
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (CFG[i]) begin : g_cfg
         logic rise;
         assign rise = lvl_in[i] & ~prev_q[i];
         assign set_out[i] = (sense == irq_pkg::SENSE_EDGE) ? rise : lvl_in[i];
      end else begin : g_lvl
         assign set_out[i] = lvl_in[i];
      end
   end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
   parameter int unsigned N     = 16,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N-1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
   parameter int unsigned LEVELS      = 16,
   parameter int unsigned NUM_USR     = 6,
   parameter int unsigned NUM_IOL     = 2,
   parameter int unsigned USR_BASE    = 2,
   parameter int unsigned IOL_BASE    = 10,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned LVL_W      = $clog2(LEVELS),
   localparam int unsigned NUM_EXT    = 1 + NUM_USR + NUM_IOL
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               edge_mode,
   input  logic               pwrdn_req,
   input  logic [NUM_USR-1:0] usr_req,
   input  logic [NUM_IOL-1:0] iol_req,
   input  logic [LEVELS-1:0]  int_set,
   input  logic               mask_we,
   input  logic [LEVELS-1:0]  mask_wdata,
   input  logic               en_we,
   input  logic               en_wdata,
   input  logic               ack,
   output logic               irq_valid,
   output logic [LVL_W-1:0]   irq_level,
   output logic [LEVELS-1:0]  pend_o
);
   import irq_pkg::*;

   localparam logic [NUM_EXT-1:0] CFG_BITS = NUM_EXT'((1 << (1 + NUM_USR)) - 1);

   if (LEVELS < 2 || (1 << LVL_W) != LEVELS) begin : g_bad_levels
      $error("irq_ctrl: LEVELS must be a power of two of at least 2");
   end
   if (USR_BASE == PWRDN_LEVEL || USR_BASE + NUM_USR > LEVELS) begin : g_bad_usr
      $error("irq_ctrl: user levels out of range");
   end
   if (IOL_BASE < USR_BASE + NUM_USR || IOL_BASE + NUM_IOL > LEVELS) begin : g_bad_iol
      $error("irq_ctrl: expansion levels overlap or out of range");
   end

   logic [NUM_EXT-1:0] ext_raw, ext_sync, ext_set;
   logic [LEVELS-1:0]  ext_lvl, pend_q, mask_q, elig, ack_clr;
   logic               en_q;
   sense_e             sense;

   assign ext_raw = {iol_req, usr_req, pwrdn_req};
   assign sense   = edge_mode ? SENSE_EDGE : SENSE_LEVEL;

   irq_sync #(.WIDTH(NUM_EXT), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (ext_raw),
      .sync_out (ext_sync)
   );

   irq_capture #(.WIDTH(NUM_EXT), .CFG(CFG_BITS)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .sense   (sense),
      .lvl_in  (ext_sync),
      .set_out (ext_set)
   );

   for (genvar l = 0; l < LEVELS; l++) begin : g_map
      if (l == PWRDN_LEVEL) begin : g_pd
         assign ext_lvl[l] = ext_set[0];
      end else if (l >= USR_BASE && l < USR_BASE + NUM_USR) begin : g_usr
         assign ext_lvl[l] = ext_set[1 + l - USR_BASE];
      end else if (l >= IOL_BASE && l < IOL_BASE + NUM_IOL) begin : g_iol
         assign ext_lvl[l] = ext_set[1 + NUM_USR + l - IOL_BASE];
      end else begin : g_none
         assign ext_lvl[l] = 1'b0;
      end
   end

   for (genvar l = 0; l < LEVELS; l++) begin : g_elig
      if (l == PWRDN_LEVEL) begin : g_nmi
         assign elig[l] = pend_q[l];
      end else begin : g_gated
         assign elig[l] = pend_q[l] & mask_q[l] & en_q;
      end
   end

   irq_prio #(.N(LEVELS)) u_prio (
      .req (elig),
      .any (irq_valid),
      .idx (irq_level)
   );

   always_comb begin
      ack_clr = '0;
      if (ack && irq_valid) begin
         ack_clr[irq_level] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         mask_q <= '0;
         en_q   <= 1'b0;
      end else begin
         pend_q <= (pend_q | int_set | ext_lvl) & ~ack_clr;
         if (mask_we) mask_q <= mask_wdata;
         if (en_we)   en_q   <= en_wdata;
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int unsigned LEVELS = 16,
   localparam int unsigned LVL_W = $clog2(LEVELS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic [LEVELS-1:0] int_set,
   input logic              irq_valid,
   input logic [LVL_W-1:0]  irq_level,
   input logic [LEVELS-1:0] pend_o,
   input logic [LEVELS-1:0] mask_q,
   input logic              en_q
);
   // R3
   presented_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> pend_o[irq_level]);

   // R6
   pwrdn_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_o[0] |-> (irq_valid && irq_level == '0));

   // R5
   enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && irq_valid) |-> (irq_level == '0));

   // R4
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_valid && irq_level != '0) |-> mask_q[irq_level]);

   // R10
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_valid) |=> !pend_o[$past(irq_level)]);

   // R2
   int_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|int_set) && !ack) |=> ((pend_o & $past(int_set)) == $past(int_set)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.LEVELS(LEVELS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack       (ack),
   .int_set   (int_set),
   .irq_valid (irq_valid),
   .irq_level (irq_level),
   .pend_o    (pend_o),
   .mask_q    (mask_q),
   .en_q      (en_q)
);

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        edge_mode = 1'b0;
   logic        pwrdn_req = 1'b0;
   logic [5:0]  usr_req = '0;
   logic [1:0]  iol_req = '0;
   logic [15:0] int_set = '0;
   logic        mask_we = 1'b0;
   logic [15:0] mask_wdata = '0;
   logic        en_we = 1'b0;
   logic        en_wdata = 1'b0;
   logic        ack = 1'b0;
   logic        irq_valid;
   logic [3:0]  irq_level;
   logic [15:0] pend_o;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   string       tag_q[$];
   logic [20:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .pwrdn_req(pwrdn_req),
      .usr_req(usr_req), .iol_req(iol_req), .int_set(int_set),
      .mask_we(mask_we), .mask_wdata(mask_wdata), .en_we(en_we),
      .en_wdata(en_wdata), .ack(ack), .irq_valid(irq_valid),
      .irq_level(irq_level), .pend_o(pend_o)
   );

   // monitor: pops expectations and compares with the outputs at the falling edge
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         automatic logic [20:0] e = exp_q.pop_front();
         automatic string t = tag_q.pop_front();
         automatic logic [20:0] a = {irq_valid, irq_level, pend_o};
         automatic bit bad;
         checks++;
         bad = (a[20] !== e[20]) || (a[15:0] !== e[15:0]) ||
               (e[20] && (a[19:16] !== e[19:16]));
         if (bad) begin
            fails++;
            $display("FAIL %s: actual valid=%0b level=%0d pend=%04h, expected valid=%0b level=%0d pend=%04h",
                     t, a[20], a[19:16], a[15:0], e[20], e[19:16], e[15:0]);
         end
      end
   end

   task automatic step(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input string tag, input logic v, input logic [3:0] l,
                             input logic [15:0] p);
      tag_q.push_back(tag);
      exp_q.push_back({v, l, p});
   endtask

   task automatic pulse_ack();
      ack = 1'b1;
      step();
      ack = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: actual still running, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step();
      expect_out("R1 reset state", 1'b0, 4'd0, 16'h0000);

      // R2: internal set, still masked and disabled after reset (R1)
      int_set = 16'h0020; step(); int_set = '0;
      expect_out("R2 int_set lands, R1 mask/enable zero", 1'b0, 4'd0, 16'h0020);

      en_we = 1'b1; en_wdata = 1'b1; step(); en_we = 1'b0;
      expect_out("R4 masked level held back", 1'b0, 4'd0, 16'h0020);

      mask_we = 1'b1; mask_wdata = 16'hFFFF; step(); mask_we = 1'b0;
      expect_out("R3 single eligible level", 1'b1, 4'd5, 16'h0020);

      int_set = 16'h0208; step(); int_set = '0;
      expect_out("R3 lowest index wins", 1'b1, 4'd3, 16'h0228);

      pulse_ack();
      expect_out("R10 ack clears winner only", 1'b1, 4'd5, 16'h0220);

      mask_we = 1'b1; mask_wdata = 16'hFFDE; step(); mask_we = 1'b0;
      expect_out("R4 mask skips level 5", 1'b1, 4'd9, 16'h0220);

      en_we = 1'b1; en_wdata = 1'b0; step(); en_we = 1'b0;
      expect_out("R5 master enable off", 1'b0, 4'd0, 16'h0220);

      // R7/R6: power-down pin, edge mode, mask bit 0 cleared, enable off
      edge_mode = 1'b1; pwrdn_req = 1'b1;
      step(2);
      expect_out("R7 not yet captured after two edges", 1'b0, 4'd0, 16'h0220);
      step();
      expect_out("R6 power-down unmaskable", 1'b1, 4'd0, 16'h0221);
      pulse_ack();
      expect_out("R10 power-down acked", 1'b0, 4'd0, 16'h0220);
      step(3);
      expect_out("R7 held pin no recapture", 1'b0, 4'd0, 16'h0220);
      pwrdn_req = 1'b0;
      step(3);

      // R8/R11: level mode, user pin 1 maps to level 3
      edge_mode = 1'b0;
      en_we = 1'b1; en_wdata = 1'b1; step(); en_we = 1'b0;
      expect_out("R5 enable on again", 1'b1, 4'd9, 16'h0220);
      usr_req[1] = 1'b1;
      step(3);
      expect_out("R11 user pin 1 at level 3, R8 level capture", 1'b1, 4'd3, 16'h0228);
      pulse_ack();
      expect_out("R10 clear beats level set", 1'b1, 4'd5 + 4'd4, 16'h0220);
      step();
      expect_out("R8 level recapture after ack", 1'b1, 4'd3, 16'h0228);
      usr_req[1] = 1'b0;
      step(3);
      pulse_ack();
      step(2);
      expect_out("R8 released pin stays clear", 1'b1, 4'd9, 16'h0220);

      // R9: expansion pin 0 (level 10) in edge mode behaves as level
      edge_mode = 1'b1; iol_req[0] = 1'b1;
      step(3);
      expect_out("R11 expansion pin 0 at level 10", 1'b1, 4'd9, 16'h0620);
      pulse_ack();
      expect_out("R3 level 10 next", 1'b1, 4'd10, 16'h0420);
      pulse_ack();
      expect_out("R10 level 10 cleared", 1'b0, 4'd0, 16'h0020);
      step();
      expect_out("R9 expansion pin level in edge mode", 1'b1, 4'd10, 16'h0420);
      iol_req[0] = 1'b0;
      step(3);
      pulse_ack();
      step();
      expect_out("R9 released expansion pin", 1'b0, 4'd0, 16'h0020);

      // R7: single-cycle pulse on user pin 5 (level 7) is captured and sticky
      usr_req[5] = 1'b1; step(); usr_req[5] = 1'b0;
      step(2);
      expect_out("R7 short pulse captured, R11 user 5 at level 7", 1'b1, 4'd7, 16'h00A0);
      step(2);
      expect_out("R7 edge bit sticky", 1'b1, 4'd7, 16'h00A0);

      // R10: clear wins over int_set of the same level
      int_set = 16'h0080; ack = 1'b1; step(); int_set = '0; ack = 1'b0;
      expect_out("R10 clear beats int_set", 1'b0, 4'd0, 16'h0020);

      @(negedge clk);
      #1;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule